// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block keeps speculative access state for a small, fully associative cache that runs hardware transactions. Each cache line has a coherence state (Invalid, Shared or Modified), a line-address tag, and two tracking flags. One flag marks that the open transaction has read the line. The other marks that it has written the line. The processor opens, closes and cancels transactions and issues loads and stores by line address. Snooped coherence requests from other agents are checked against the tracked lines. Each snoop is answered one cycle later, either with a normal response or with a negative acknowledgement. A normal response flags whether this cache held the line dirty and supplies it.

Two static configuration inputs select the conflict handling. One chooses when a conflict is acted on: at once (eager) or at the outermost commit (lazy). The other chooses which side gives way: the remote requester wins and the local transaction loses, or the remote requester is refused and must retry. When a transaction is cancelled, every line it wrote is dropped to Invalid and all tracking flags are cleared. The processor then gets a one-cycle abort pulse so it can roll back. A successful commit clears all flags at once, keeps the written lines Modified, and pulses commit-done. Data storage, the wider coherence engine and the processor's rollback are outside the block.

Top module: `tct_top`

## Requirements
- R1: Inside an open transaction, a load sets the line's read flag and a store sets its write flag. A store also makes the line Modified. A load that misses allocates the line as Shared, using the lowest-numbered line that has no flag set.
- R2: A snooped invalidation (snp_inval_i=1) that hits a line with its read or write flag set is a conflict. A snooped intervention (snp_inval_i=0) conflicts only when it hits a line with its write flag set. An intervention that hits a line with only the read flag set is not a conflict.
- R3: With cfg_lazy_i=0 and cfg_stall_i=0, a conflicting snoop gets a normal response (snp_nack_o=0) one cycle later. In that same cycle, tx_abort_o pulses high for one cycle.
- R4: With cfg_stall_i=1, a conflicting snoop is answered with snp_nack_o=1 one cycle later. The line's state and flags stay unchanged, no abort is raised, and the transaction can still commit.
- R5: With cfg_lazy_i=1, a conflict raises no abort when the snoop arrives. Instead, the next outermost commit becomes an abort: tx_abort_o pulses and commit_done_o stays low.
- R6: On any abort, every line with its write flag set becomes Invalid, so a later access to it misses. Lines that were only read stay valid. All flags are cleared.
- R7: An outermost commit with no pending conflict clears all flags and leaves the written lines Modified. In the next cycle, commit_done_o pulses for one cycle, and it is never high together with tx_abort_o.
- R8: Inside a transaction, an access that misses while every line has a flag set raises an abort, and no tracked line is evicted.
- R9: An access made while no transaction is open sets no flag. A snoop that hits a line with no flag set never causes a negative acknowledgement or an abort.
- R10: A begin while a transaction is open adds one nesting level, up to 2^DEPTH_W-1 levels. A commit below the outermost level only removes a level: no commit-done pulse, and the flags are kept.
- R11: tx_abort_i while a transaction is open aborts it as in R6, with a tx_abort_o pulse one cycle later. tx_abort_i while no transaction is open does nothing.
- R12: Every snoop gives snp_resp_valid_o one cycle later. snp_dirty_o is set when the snoop hit a Modified line and was not refused. Every access gives acc_hit_o one cycle later, set when the access hit a valid line. After reset, all outputs are 0 and all lines are Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_lazy_i | input | 1 | 1 = act on conflicts at commit, 0 = at once |
| cfg_stall_i | input | 1 | 1 = refuse conflicting snoops, 0 = requester wins |
| tx_begin_i | input | 1 | Open a transaction or one more nesting level |
| tx_commit_i | input | 1 | Close one nesting level |
| tx_abort_i | input | 1 | Processor request to cancel the transaction |
| acc_valid_i | input | 1 | Processor access present |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_line_i | input | LINE_W | Line address of the access |
| snp_valid_i | input | 1 | Snooped request present |
| snp_inval_i | input | 1 | 1 = invalidation, 0 = intervention |
| snp_line_i | input | LINE_W | Line address of the snoop |
| acc_hit_o | output | 1 | Previous cycle's access hit a valid line |
| snp_resp_valid_o | output | 1 | Response to the previous cycle's snoop |
| snp_nack_o | output | 1 | Response is a negative acknowledgement |
| snp_dirty_o | output | 1 | Response supplies a Modified line |
| tx_abort_o | output | 1 | One-cycle abort pulse to the processor |
| commit_done_o | output | 1 | One-cycle successful commit pulse |

## Verification
The assertions check the following on every cycle:
- every snoop gets exactly one response one cycle later;
- a refusal appears only under the stalling policy;
- no flag is set while no transaction is open;
- all flags are clear in the cycle of an abort or commit pulse, and the two pulses never coincide;
- the nesting depth rises by at most one per cycle.

Some effects only show in the bench's scenarios, because each depends on a particular sequence of accesses and snoops:
- which snoops count as conflicts under each mode pair;
- that a lazy conflict turns the commit into an abort;
- that written lines are dropped while read lines survive;
- the capacity abort on the fifth tracked line;
- that commit-done waits for the outermost level.

// File: rtl/tct_pkg.sv
package tct_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2
  } line_state_e;
endpackage

// File: rtl/tct_match.sv
// Fully associative tag compare: finds the valid line holding a line address.
module tct_match #(
  parameter int N     = 4,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [TAG_W-1:0] tags_i [N],
  input  logic [N-1:0]     valid_i,
  input  logic [TAG_W-1:0] key_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/tct_victim.sv
// Picks the lowest-numbered line with no tracking flag set.
module tct_victim #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     busy_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = ~&busy_i;
endmodule

// File: rtl/tct_nest.sv
// Transaction nesting depth; flattened so that only the outermost level counts.
module tct_nest #(
  parameter int DEPTH_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               begin_i,
  input  logic               commit_i,
  input  logic               flush_i,
  output logic               active_o,
  output logic               outer_o,
  output logic [DEPTH_W-1:0] depth_o
);
  localparam logic [DEPTH_W-1:0] DMAX = '1;
  localparam logic [DEPTH_W-1:0] DONE = DEPTH_W'(1);

  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               depth_en;

  always_comb begin
    depth_d = depth_q;
    if (flush_i)                               depth_d = '0;
    else if (begin_i && (depth_q != DMAX))     depth_d = depth_q + DONE;
    else if (commit_i && (depth_q != '0))      depth_d = depth_q - DONE;
  end

  assign depth_en = flush_i | begin_i | commit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        depth_q <= '0;
    else if (depth_en) depth_q <= depth_d;
  end

  assign active_o = (depth_q != '0);
  assign outer_o  = commit_i && (depth_q == DONE);
  assign depth_o  = depth_q;
endmodule

// File: rtl/tct_top.sv
module tct_top #(
  parameter int N       = 4,
  parameter int LINE_W  = 12,
  parameter int DEPTH_W = 3,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lazy_i,
  input  logic              cfg_stall_i,
  input  logic              tx_begin_i,
  input  logic              tx_commit_i,
  input  logic              tx_abort_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [LINE_W-1:0] acc_line_i,
  input  logic              snp_valid_i,
  input  logic              snp_inval_i,
  input  logic [LINE_W-1:0] snp_line_i,
  output logic              acc_hit_o,
  output logic              snp_resp_valid_o,
  output logic              snp_nack_o,
  output logic              snp_dirty_o,
  output logic              tx_abort_o,
  output logic              commit_done_o
);
  import tct_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  line_state_e       st_q  [N];
  line_state_e       st_d  [N];
  logic [LINE_W-1:0] tag_q [N];
  logic [LINE_W-1:0] tag_d [N];
  logic [N-1:0]      rd_q, rd_d, wr_q, wr_d, valid_v;
  logic              pend_q, pend_d;

  for (genvar g = 0; g < N; g++) begin : g_valid
    assign valid_v[g] = (st_q[g] != LS_INV);
  end

  // lookups
  logic             a_hit, s_hit, v_found;
  logic [IDX_W-1:0] a_hidx, s_idx, v_idx, a_idx;

  tct_match #(.N(N), .TAG_W(LINE_W)) u_amatch (
    .tags_i(tag_q), .valid_i(valid_v), .key_i(acc_line_i),
    .hit_o(a_hit), .idx_o(a_hidx));

  tct_match #(.N(N), .TAG_W(LINE_W)) u_smatch (
    .tags_i(tag_q), .valid_i(valid_v), .key_i(snp_line_i),
    .hit_o(s_hit), .idx_o(s_idx));

  tct_victim #(.N(N)) u_victim (
    .busy_i(rd_q | wr_q), .found_o(v_found), .idx_o(v_idx));

  // nesting
  logic               active, outer_commit, abort_all;
  logic [DEPTH_W-1:0] nest_depth;

  tct_nest #(.DEPTH_W(DEPTH_W)) u_nest (
    .clk(clk), .rst_n(rst_sync_n),
    .begin_i(tx_begin_i), .commit_i(tx_commit_i), .flush_i(abort_all),
    .active_o(active), .outer_o(outer_commit), .depth_o(nest_depth));

  // conflict decision
  logic s_rd, s_wr, conflict, refuse, snp_apply;
  logic cap_abort, eager_abort, lazy_abort, req_abort, commit_ok, acc_do;

  assign s_rd      = s_hit && rd_q[s_idx];
  assign s_wr      = s_hit && wr_q[s_idx];
  assign conflict  = snp_valid_i && active && (s_wr || (snp_inval_i && s_rd));
  assign refuse    = conflict && cfg_stall_i;
  assign snp_apply = snp_valid_i && s_hit && !refuse;

  assign cap_abort   = acc_valid_i && active && !a_hit && !v_found;
  assign eager_abort = conflict && !cfg_lazy_i && !cfg_stall_i;
  assign lazy_abort  = outer_commit && (pend_q || (conflict && cfg_lazy_i));
  assign req_abort   = tx_abort_i && active;
  assign abort_all   = cap_abort || eager_abort || lazy_abort || req_abort;
  assign commit_ok   = outer_commit && !abort_all;

  assign acc_do = acc_valid_i && (a_hit || v_found);
  assign a_idx  = a_hit ? a_hidx : v_idx;

  // line next state
  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    rd_d   = rd_q;
    wr_d   = wr_q;
    pend_d = pend_q;
    if (snp_apply) begin
      if (snp_inval_i)                st_d[s_idx] = LS_INV;
      else if (st_q[s_idx] == LS_MOD) st_d[s_idx] = LS_SHR;
    end
    if (abort_all) begin
      for (int i = 0; i < N; i++) begin
        if (wr_q[i]) st_d[i] = LS_INV;
      end
      rd_d   = '0;
      wr_d   = '0;
      pend_d = 1'b0;
    end else begin
      if (acc_do) begin
        tag_d[a_idx] = acc_line_i;
        if (acc_write_i)  st_d[a_idx] = LS_MOD;
        else if (!a_hit)  st_d[a_idx] = LS_SHR;
        if (active && acc_write_i)  wr_d[a_idx] = 1'b1;
        if (active && !acc_write_i) rd_d[a_idx] = 1'b1;
      end
      if (conflict && cfg_lazy_i) pend_d = 1'b1;
      if (commit_ok) begin
        rd_d   = '0;
        wr_d   = '0;
        pend_d = 1'b0;
      end
    end
  end

  logic line_en;
  assign line_en = acc_valid_i | snp_valid_i | abort_all | commit_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < N; i++) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
      end
      rd_q   <= '0;
      wr_q   <= '0;
      pend_q <= 1'b0;
    end else if (line_en) begin
      st_q   <= st_d;
      tag_q  <= tag_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      pend_q <= pend_d;
    end
  end

  // registered outputs
  logic hit_d, rv_d, nack_d, dirty_d;
  assign hit_d   = acc_valid_i && a_hit;
  assign rv_d    = snp_valid_i;
  assign nack_d  = refuse;
  assign dirty_d = snp_valid_i && s_hit && (st_q[s_idx] == LS_MOD) && !refuse;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_hit_o        <= 1'b0;
      snp_resp_valid_o <= 1'b0;
      snp_nack_o       <= 1'b0;
      snp_dirty_o      <= 1'b0;
      tx_abort_o       <= 1'b0;
      commit_done_o    <= 1'b0;
    end else begin
      acc_hit_o        <= hit_d;
      snp_resp_valid_o <= rv_d;
      snp_nack_o       <= nack_d;
      snp_dirty_o      <= dirty_d;
      tx_abort_o       <= abort_all;
      commit_done_o    <= commit_ok;
    end
  end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int N       = 4,
  parameter int DEPTH_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_stall_i,
  input logic               snp_valid_i,
  input logic               snp_resp_valid_o,
  input logic               snp_nack_o,
  input logic               tx_abort_o,
  input logic               commit_done_o,
  input logic [N-1:0]       rd_vec,
  input logic [N-1:0]       wr_vec,
  input logic [DEPTH_W-1:0] depth
);
  // R12
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid_i |=> snp_resp_valid_o);
  // R12
  resp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid_i |=> !snp_resp_valid_o);
  // R4
  nack_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_nack_o |-> ($past(cfg_stall_i) && snp_resp_valid_o));
  // R6
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort_o |-> (rd_vec == '0 && wr_vec == '0 && depth == '0));
  // R7
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done_o |-> (rd_vec == '0 && wr_vec == '0 && depth == '0));
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_abort_o && commit_done_o));
  // R9
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth == '0) |-> (rd_vec == '0 && wr_vec == '0));
  // R10
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth > $past(depth)) |-> (depth == $past(depth) + DEPTH_W'(1)));
endmodule

bind tct_top tct_checker #(.N(N), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_stall_i(cfg_stall_i),
  .snp_valid_i(snp_valid_i), .snp_resp_valid_o(snp_resp_valid_o),
  .snp_nack_o(snp_nack_o), .tx_abort_o(tx_abort_o),
  .commit_done_o(commit_done_o), .rd_vec(rd_q), .wr_vec(wr_q),
  .depth(nest_depth));

// File: tb/tct_top_test.sv
module tct_top_test;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_lazy, cfg_stall, tb_begin, tb_commit, tb_abort;
  logic acc_v, acc_w, snp_v, snp_inv;
  logic [LW-1:0] acc_l, snp_l;
  logic acc_hit, rv, nack, dirty, abrt, cdone;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tct_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_lazy_i(cfg_lazy), .cfg_stall_i(cfg_stall),
    .tx_begin_i(tb_begin), .tx_commit_i(tb_commit), .tx_abort_i(tb_abort),
    .acc_valid_i(acc_v), .acc_write_i(acc_w), .acc_line_i(acc_l),
    .snp_valid_i(snp_v), .snp_inval_i(snp_inv), .snp_line_i(snp_l),
    .acc_hit_o(acc_hit), .snp_resp_valid_o(rv), .snp_nack_o(nack),
    .snp_dirty_o(dirty), .tx_abort_o(abrt), .commit_done_o(cdone));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // inputs are driven after a falling edge; outputs are read at the next one
  task automatic tick();
    @(negedge clk);
    tb_begin = 0; tb_commit = 0; tb_abort = 0; acc_v = 0; snp_v = 0;
  endtask

  task automatic op_begin();  tb_begin = 1;  tick(); endtask
  task automatic op_commit(); tb_commit = 1; tick(); endtask
  task automatic op_abort();  tb_abort = 1;  tick(); endtask
  task automatic op_acc(logic w, logic [LW-1:0] l);
    acc_v = 1; acc_w = w; acc_l = l; tick();
  endtask
  task automatic op_snp(logic inv, logic [LW-1:0] l);
    snp_v = 1; snp_inv = inv; snp_l = l; tick();
  endtask

  task automatic t_reset();
    chk("R12 reset hit", acc_hit, 0);
    chk("R12 reset resp", rv, 0);
    chk("R12 reset abort", abrt, 0);
    chk("R12 reset commit", cdone, 0);
    op_acc(0, 12'h010);
    chk("R12 cold miss", acc_hit, 0);
  endtask

  task automatic t_stall();
    cfg_lazy = 0; cfg_stall = 1;
    op_acc(0, 12'h020);
    op_begin();
    op_snp(1, 12'h020);
    chk("R9 untracked resp", rv, 1);
    chk("R9 untracked nack", nack, 0);
    op_acc(0, 12'h021);
    op_acc(1, 12'h022);
    op_snp(0, 12'h021);
    chk("R2 intervention on read line nack", nack, 0);
    chk("R2 intervention on read line dirty", dirty, 0);
    op_snp(1, 12'h021);
    chk("R2 invalidation on read line nack", nack, 1);
    chk("R4 no abort", abrt, 0);
    op_snp(0, 12'h022);
    chk("R4 intervention on written nack", nack, 1);
    op_acc(0, 12'h021);
    chk("R4 refused line kept", acc_hit, 1);
    op_commit();
    chk("R4 commit done", cdone, 1);
    chk("R4 commit no abort", abrt, 0);
    tick();
    chk("R7 commit pulse ends", cdone, 0);
    op_snp(0, 12'h022);
    chk("R7 written line Modified nack", nack, 0);
    chk("R7 written line Modified dirty", dirty, 1);
  endtask

  task automatic t_eager();
    cfg_lazy = 0; cfg_stall = 0;
    op_begin();
    op_acc(0, 12'h031);
    op_acc(1, 12'h032);
    op_acc(0, 12'h033);
    op_snp(1, 12'h031);
    chk("R3 response not refused", nack, 0);
    chk("R3 abort pulse", abrt, 1);
    tick();
    chk("R3 abort one cycle", abrt, 0);
    op_acc(0, 12'h032);
    chk("R6 written line invalid", acc_hit, 0);
    op_acc(0, 12'h033);
    chk("R6 read line kept", acc_hit, 1);
    cfg_stall = 1;
    op_snp(1, 12'h033);
    chk("R6 flags cleared", nack, 0);
    op_commit();
    chk("R10 commit when idle", cdone, 0);
  endtask

  task automatic t_lazy();
    cfg_lazy = 1; cfg_stall = 0;
    op_begin();
    op_acc(1, 12'h041);
    op_snp(0, 12'h041);
    chk("R5 no abort at snoop", abrt, 0);
    chk("R5 dirty supplied", dirty, 1);
    op_commit();
    chk("R5 commit becomes abort", abrt, 1);
    chk("R5 no commit done", cdone, 0);
  endtask

  task automatic t_capacity();
    cfg_lazy = 0; cfg_stall = 0;
    op_begin();
    for (int i = 0; i < 4; i++) op_acc(1, 12'h050 + LW'(i));
    chk("R8 four lines fit", abrt, 0);
    op_acc(1, 12'h054);
    chk("R8 capacity abort", abrt, 1);
    op_acc(0, 12'h050);
    chk("R8 tracked line not kept after abort", acc_hit, 0);
  endtask

  task automatic t_nest();
    cfg_lazy = 0; cfg_stall = 1;
    op_begin();
    op_begin();
    op_acc(1, 12'h061);
    op_commit();
    chk("R10 inner commit no pulse", cdone, 0);
    op_snp(0, 12'h061);
    chk("R10 flags kept after inner commit", nack, 1);
    op_commit();
    chk("R10 outer commit pulse", cdone, 1);
  endtask

  task automatic t_proc_abort();
    cfg_lazy = 0; cfg_stall = 0;
    op_abort();
    chk("R11 idle abort ignored", abrt, 0);
    op_begin();
    op_acc(1, 12'h071);
    op_acc(0, 12'h072);
    op_abort();
    chk("R11 abort pulse", abrt, 1);
    op_acc(0, 12'h071);
    chk("R11 written line dropped", acc_hit, 0);
    op_acc(0, 12'h072);
    chk("R1 read line still valid", acc_hit, 1);
  endtask

  initial begin
    rst_n = 0; cfg_lazy = 0; cfg_stall = 0;
    tb_begin = 0; tb_commit = 0; tb_abort = 0;
    acc_v = 0; acc_w = 0; acc_l = '0; snp_v = 0; snp_inv = 0; snp_l = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_stall();
    t_eager();
    t_lazy();
    t_capacity();
    t_nest();
    t_proc_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule